// File: doc/BRIEF.md
# Crosspoint Credit Tracker with Shared Return Bus

This block keeps the flow-control state for one input row of a buffered crossbar. The row holds one flit buffer for every output and virtual channel pair. For each of those buffers the input keeps a free-slot count. The count starts at the buffer depth, falls by one each time the input sends a flit into that buffer, and rises by one each time a credit for that buffer comes back. When a buffer's count is zero, the block refuses to send to it.

Crosspoints release flits on their own schedule, and several may release in the same cycle. All crosspoints of the row return their credits over one shared bus that carries a single credit per cycle. Each crosspoint therefore holds a small pending-credit count. A two-level round-robin arbiter picks the next credit to return: first within a local group of crosspoints, then across the groups. The bus driver is a two-state machine. It moves from BUS_IDLE to BUS_SEND when a crosspoint wins the bus, stays in BUS_SEND while further winners follow, and falls back to BUS_IDLE in the first cycle with nothing pending.

The input side presents one target (output and VC) per cycle. It reads that buffer's free count and a send permit, and raises a request when it sends. Buffer index i equals output*NUM_VC + vc.

Top module: `xcr_credit_row`

## Requirements
- R1: After reset every free count equals DEPTH (default 4), no credit is pending and crd_valid is low.
- R2: send_free always shows the current count of the addressed buffer. A send (send_req high while send_ok is high) lowers that count by one at the next clock edge.
- R3: send_ok is low exactly when the addressed count is zero. A send_req in that state has no effect, and the count stays at zero.
- R4: A credit on the bus (crd_valid high, with index crd_out*NUM_VC + crd_vc) raises that buffer's count by one at the end of that cycle. No count ever exceeds DEPTH.
- R5: When a send and a returning credit hit the same buffer in the same cycle, that buffer's count is unchanged.
- R6: Each depart pulse produces exactly one returned credit for its buffer, including when several crosspoints depart in the same cycle. No credit is lost or duplicated.
- R7: The bus carries at most one credit per cycle, and only for a buffer that owes one. Whenever any credit is pending, the bus is granted in the next cycle.
- R8: Return order is round-robin over the groups of GROUP adjacent buffers, and round-robin within each group; a group's pointer moves only when that group wins. From reset, with all eight default buffers pending, the order is 0,2,4,6,1,3,5,7.
- R9: A lone depart in cycle c appears on the bus in cycle c+2, and the count is higher from cycle c+3.
- R10: Once all buffers have drained and the bus is quiet, every count is back at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | Input sends a flit to the addressed buffer this cycle |
| send_out | input | $clog2(NUM_OUT) | Output index of the addressed buffer |
| send_vc | input | $clog2(NUM_VC) | VC index of the addressed buffer |
| send_ok | output | 1 | Addressed buffer has at least one free slot |
| send_free | output | $clog2(DEPTH+1) | Free count of the addressed buffer |
| depart | input | NUM_OUT*NUM_VC | One bit per buffer: a flit left that crosspoint buffer |
| crd_valid | output | 1 | A credit is on the return bus |
| crd_out | output | $clog2(NUM_OUT) | Output index of the returned credit |
| crd_vc | output | $clog2(NUM_VC) | VC index of the returned credit |

## Verification
A send and a returning credit can land on the same buffer in one cycle, and so can many departs at once. Both collide on shared state: the first on one counter, the second on the pending queues and the single-credit bus. The bench times a send into the cycle in which a known credit for that same buffer sits on the bus, and expects the count to be unchanged (R5). It also raises all depart bits together and expects eight back-to-back credits in the round-robin order. Random traffic then mixes both cases freely, and a bench model that tracks owed credits and counts checks each cycle.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_SEND = 1'b1
    } xcr_bus_e;
endpackage

// File: rtl/xcr_rr_arb.sv
module xcr_rr_arb #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic         adv,
    output logic [W-1:0] gnt
);
    localparam int PW = (W > 1) ? $clog2(W) : 1;

    logic [PW-1:0] last_q;
    logic [PW-1:0] win;
    logic          found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        win   = last_q;
        for (int off = 1; off <= W; off++) begin
            int idx;
            idx = (int'(last_q) + off) % W;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= PW'(W - 1);
        end else if (adv && found) begin
            last_q <= win;
        end
    end

    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt)); // R7
endmodule

// File: rtl/xcr_ret_arb.sv
module xcr_ret_arb #(
    parameter int N     = 8,
    parameter int GROUP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int NGRP = N / GROUP;

    logic [NGRP-1:0] grp_req;
    logic [NGRP-1:0] grp_gnt;

    for (genvar g = 0; g < NGRP; g++) begin : g_local
        logic [GROUP-1:0] loc_gnt;
        assign grp_req[g] = |req[g*GROUP +: GROUP];
        xcr_rr_arb #(.W(GROUP)) u_local (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req[g*GROUP +: GROUP]),
            .adv  (grp_gnt[g]),
            .gnt  (loc_gnt)
        );
        assign gnt[g*GROUP +: GROUP] = loc_gnt & {GROUP{grp_gnt[g]}};
    end

    xcr_rr_arb #(.W(NGRP)) u_global (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (grp_req),
        .adv  (1'b1),
        .gnt  (grp_gnt)
    );
endmodule

// File: rtl/xcr_pending.sv
module xcr_pending #(
    parameter int N     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] depart,
    input  logic [N-1:0] grant,
    output logic [N-1:0] req
);
    localparam int CW = $clog2(DEPTH + 1);

    for (genvar i = 0; i < N; i++) begin : g_pend
        logic [CW-1:0] pend_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else if (depart[i] && !grant[i]) begin
                pend_q <= pend_q + CW'(1);
            end else if (grant[i] && !depart[i]) begin
                pend_q <= pend_q - CW'(1);
            end
        end

        assign req[i] = (pend_q != '0);

        AST_GRANT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (pend_q != '0)); // R6
        AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q <= CW'(DEPTH)); // R6
    end
endmodule

// File: rtl/xcr_counter_file.sv
module xcr_counter_file #(
    parameter int N     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dec_en,
    input  logic [$clog2(N)-1:0]       dec_idx,
    input  logic                       inc_en,
    input  logic [$clog2(N)-1:0]       inc_idx,
    input  logic [$clog2(N)-1:0]       rd_idx,
    output logic [$clog2(DEPTH+1)-1:0] rd_cnt
);
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q [N];

    for (genvar i = 0; i < N; i++) begin : g_cnt
        logic inc_hit;
        logic dec_hit;
        assign inc_hit = inc_en && (inc_idx == IW'(i));
        assign dec_hit = dec_en && (dec_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[i] <= CW'(DEPTH);
            end else if (inc_hit && !dec_hit) begin
                cnt_q[i] <= cnt_q[i] + CW'(1);
            end else if (dec_hit && !inc_hit) begin
                cnt_q[i] <= cnt_q[i] - CW'(1);
            end
        end

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[i] <= CW'(DEPTH)); // R4
        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == '0 && !inc_hit) |=> (cnt_q[i] == '0)); // R3
        AST_SAME_CYCLE_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_hit && dec_hit) |=> (cnt_q[i] == $past(cnt_q[i]))); // R5
    end

    assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/xcr_credit_row.sv
module xcr_credit_row #(
    parameter int NUM_OUT = 4,
    parameter int NUM_VC  = 2,
    parameter int DEPTH   = 4,
    parameter int GROUP   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               send_req,
    input  logic [$clog2(NUM_OUT)-1:0]         send_out,
    input  logic [$clog2(NUM_VC)-1:0]          send_vc,
    output logic                               send_ok,
    output logic [$clog2(DEPTH+1)-1:0]         send_free,
    input  logic [NUM_OUT*NUM_VC-1:0]          depart,
    output logic                               crd_valid,
    output logic [$clog2(NUM_OUT)-1:0]         crd_out,
    output logic [$clog2(NUM_VC)-1:0]          crd_vc
);
    import xcr_pkg::*;

    localparam int N  = NUM_OUT * NUM_VC;
    localparam int IW = $clog2(N);
    localparam int OW = $clog2(NUM_OUT);
    localparam int VW = $clog2(NUM_VC);

    logic [N-1:0]  pend_req;
    logic [N-1:0]  grant;
    logic [IW-1:0] gnt_idx;
    logic [IW-1:0] crd_idx_q;
    logic [IW-1:0] tgt_idx;
    xcr_bus_e      state_q;
    xcr_bus_e      state_d;

    assign tgt_idx = IW'(send_out) * IW'(NUM_VC) + IW'(send_vc);

    xcr_pending #(.N(N), .DEPTH(DEPTH)) u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .depart(depart),
        .grant (grant),
        .req   (pend_req)
    );

    xcr_ret_arb #(.N(N), .GROUP(GROUP)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (pend_req),
        .gnt  (grant)
    );

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) gnt_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= BUS_IDLE;
            crd_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (|grant) crd_idx_q <= gnt_idx;
        end
    end

    always_comb begin
        state_d   = state_q;
        crd_valid = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (|grant) state_d = BUS_SEND;
            end
            BUS_SEND: begin
                crd_valid = 1'b1;
                if (!(|grant)) state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    assign crd_out = OW'(crd_idx_q / IW'(NUM_VC));
    assign crd_vc  = VW'(crd_idx_q % IW'(NUM_VC));

    xcr_counter_file #(.N(N), .DEPTH(DEPTH)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_en (send_req && send_ok),
        .dec_idx(tgt_idx),
        .inc_en (crd_valid),
        .inc_idx(crd_idx_q),
        .rd_idx (tgt_idx),
        .rd_cnt (send_free)
    );

    assign send_ok = (send_free != '0);

    AST_BUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_BUS_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_req) |=> crd_valid); // R7
endmodule

// File: tb/xcr_credit_row_tb.sv
module xcr_credit_row_tb;
    localparam int NO = 4;
    localparam int NV = 2;
    localparam int D  = 4;
    localparam int G  = 2;
    localparam int N  = NO * NV;
    localparam int NG = N / G;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       send_req;
    logic [1:0] send_out;
    logic [0:0] send_vc;
    logic       send_ok;
    logic [2:0] send_free;
    logic [N-1:0] depart;
    logic       crd_valid;
    logic [1:0] crd_out;
    logic [0:0] crd_vc;

    always #2 clk = ~clk;

    xcr_credit_row u_dut (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_out(send_out),
        .send_vc(send_vc), .send_ok(send_ok), .send_free(send_free),
        .depart(depart), .crd_valid(crd_valid), .crd_out(crd_out), .crd_vc(crd_vc)
    );

    int errs = 0;
    int checks = 0;
    int m_cnt [N];
    int m_occ [N];
    int m_fly [N];
    logic s_ok;
    logic s_crd_v;
    int   s_free;
    int   s_crd_idx;

    function automatic int exp_order(input int k);
        return (k % NG) * G + k / NG;
    endfunction

    function automatic bit any_occ();
        for (int i = 0; i < N; i++) if (m_occ[i] > 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit rq, input int idx, input logic [N-1:0] dep);
        bit fire;
        @(negedge clk);
        send_req = rq;
        send_out = 2'(idx / NV);
        send_vc  = 1'(idx % NV);
        depart   = dep;
        #1;
        s_ok      = send_ok;
        s_free    = int'(send_free);
        s_crd_v   = crd_valid;
        s_crd_idx = int'(crd_out) * NV + int'(crd_vc);
        chk(s_free == m_cnt[idx], "R2 free count", s_free, m_cnt[idx]);
        chk(s_ok == (m_cnt[idx] > 0), "R3 send permit", int'(s_ok), int'(m_cnt[idx] > 0));
        fire = rq && (m_cnt[idx] > 0);
        if (s_crd_v) begin
            chk(m_fly[s_crd_idx] > 0, "R7 credit owed", m_fly[s_crd_idx], 1);
            if (m_fly[s_crd_idx] > 0) begin
                m_fly[s_crd_idx]--;
                m_cnt[s_crd_idx]++;
            end
            chk(m_cnt[s_crd_idx] <= D + (fire && idx == s_crd_idx ? 1 : 0),
                "R4 count bound", m_cnt[s_crd_idx], D);
        end
        if (fire) begin
            m_cnt[idx]--;
            m_occ[idx]++;
        end
        for (int i = 0; i < N; i++) begin
            if (dep[i] && m_occ[i] > 0) begin
                m_occ[i]--;
                m_fly[i]++;
            end
        end
    endtask

    task automatic drain_and_check();
        while (any_occ()) begin
            logic [N-1:0] mask;
            for (int i = 0; i < N; i++) mask[i] = (m_occ[i] > 0);
            step(1'b0, 0, mask);
        end
        repeat (2 * N + 8) step(1'b0, 0, '0);
        for (int i = 0; i < N; i++) begin
            step(1'b0, i, '0);
            chk(s_free == D, "R10 full after drain", s_free, D);
        end
        chk(!s_crd_v, "R10 bus idle after drain", int'(s_crd_v), 0);
    endtask

    initial begin
        #(200000 * 4);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = D;
            m_occ[i] = 0;
            m_fly[i] = 0;
        end
        rst_n = 1'b0;
        send_req = 1'b0;
        send_out = '0;
        send_vc = '0;
        depart = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < N; i++) begin
            step(1'b0, i, '0);
            chk(s_free == D && s_ok, "R1 reset count", s_free, D);
        end
        chk(!s_crd_v, "R1 bus idle", int'(s_crd_v), 0);

        // R8 / R6: one flit everywhere, all depart together
        for (int i = 0; i < N; i++) step(1'b1, i, '0);
        step(1'b0, 0, '1);
        step(1'b0, 0, '0);
        chk(!s_crd_v, "R9 no credit one cycle after depart", int'(s_crd_v), 0);
        for (int k = 0; k < N; k++) begin
            step(1'b0, 0, '0);
            chk(s_crd_v && s_crd_idx == exp_order(k), "R8 return order", s_crd_idx, exp_order(k));
        end
        step(1'b0, 0, '0);
        chk(!s_crd_v, "R6 no duplicate credit", int'(s_crd_v), 0);
        for (int i = 0; i < N; i++) begin
            step(1'b0, i, '0);
            chk(s_free == D, "R6 every credit back", s_free, D);
        end

        // R2 / R3: exhaust buffer 5
        for (int k = 0; k < D; k++) step(1'b1, 5, '0);
        step(1'b1, 5, '0);
        chk(!s_ok && s_free == 0, "R3 blocked at zero", s_free, 0);
        step(1'b0, 5, '0);
        chk(s_free == 0, "R3 refused send has no effect", s_free, 0);

        // R9: lone credit latency
        step(1'b0, 5, 8'h20);
        step(1'b0, 5, '0);
        chk(!s_crd_v, "R9 not yet on bus", int'(s_crd_v), 0);
        step(1'b0, 5, '0);
        chk(s_crd_v && s_crd_idx == 5, "R9 credit at c+2", s_crd_idx, 5);
        step(1'b0, 5, '0);
        chk(s_free == 1, "R4 count raised", s_free, 1);

        // R5: send and credit return to the same buffer together
        step(1'b0, 5, 8'h20);
        step(1'b0, 5, '0);
        step(1'b1, 5, '0);
        chk(s_crd_v && s_crd_idx == 5 && s_ok, "R5 collision set up", s_crd_idx, 5);
        step(1'b0, 5, '0);
        chk(s_free == 1, "R5 net zero", s_free, 1);

        drain_and_check();

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            logic [N-1:0] dep;
            int idx;
            bit rq;
            idx = int'($urandom % N);
            rq  = ($urandom % 10) < 6;
            for (int i = 0; i < N; i++) dep[i] = (m_occ[i] > 0) && (($urandom % 10) < 3);
            step(rq, idx, dep);
        end
        drain_and_check();

        finish_run();
    end
endmodule